// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counter Bank

This block keeps running frame statistics for both directions of an Ethernet MAC. Two event streams, one for transmitted frames and one for received frames, each carry the byte length of a frame that has just completed. For every accepted event the bank updates several counters of that direction at once: the packet count, the byte total, the good-frame count, the good-byte total, and exactly one bucket of a length histogram. The histogram bucket is picked by fixed length thresholds. Transmit and receive counters live in separate index groups, so one event of each direction can be taken in the same cycle.

A host reaches every counter through a simple word-addressed register bus. Counter `k` sits at byte address `0x200 + 4*k`. A write replaces the counter value. A read returns the counter value one cycle later. Counters for drops, CRC errors, collisions and similar conditions have an index in the map, but nothing in the block increments them. Only the host changes them.

Each event port is valid/ready. A frame is taken in every cycle where both valid and ready are high. The bank holds ready low only in the first cycle after reset. After that, ready stays high, so it never applies back-pressure, and the source may present a new frame on every clock.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter reads zero. `bus_rdata` and `bus_err` are low. Both ready outputs go high on the first clock after reset and stay high.
- R2: Each accepted frame adds one to its direction's packet counter and one to its good-frame counter. Transmit uses index 1 and index 19. Receive uses index 33 and index 51.
- R3: Each accepted frame adds its length to its direction's octet counter and to its good-octet counter. Transmit uses index 17 and index 29. Receive uses index 49 and index 56.
- R4: Each accepted transmit frame adds one to exactly one size counter, chosen by its length:
  - below 64 bytes: index 7
  - exactly 64 bytes: index 10
  - 65 to 127 bytes: index 11
  - 128 to 255 bytes: index 12
  - 256 to 511 bytes: index 13
  - 512 to 1023 bytes: index 14
  - 1024 to 2047 bytes: index 15
  - 2048 bytes and above: index 16
- R5: Receive frames use the same thresholds. The size counters are index 39 for below 64 bytes, then index 42 up to index 48 in ascending length order. Index 41 is a reserved counter: the host can write it, but no event ever increments it.
- R6: A transmit frame and a receive frame accepted in the same cycle are both fully counted.
- R7: Counters wrap modulo 2^CNT_W and never saturate.
- R8: A host write (`bus_sel=1`, `bus_wr=1`) to a valid counter address replaces that counter's value. A host read (`bus_sel=1`, `bus_wr=0`) returns the counter value on `bus_rdata` in the next cycle. That value is the one held before any update made in the read cycle. `bus_rdata` is zero in the cycle after any cycle without a valid read.
- R9: When a host write and a frame update hit the same counter in the same cycle, the written value wins. The other counters touched by that frame are still updated.
- R10: An access is bad in any of these cases: the address is below 0x200, the address is above 0x2E0, the address is not a multiple of 4, or the address selects unused index 30 or 31. A bad access changes no counter. A bad read returns zero. `bus_err` is high for exactly the one cycle after each bad access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit frame-complete event present |
| tx_ready | output | 1 | Bank accepts transmit events |
| tx_len | input | LEN_W (16) | Transmit frame length in bytes |
| rx_valid | input | 1 | Receive frame-complete event present |
| rx_ready | output | 1 | Bank accepts receive events |
| rx_len | input | LEN_W (16) | Receive frame length in bytes |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Host byte address |
| bus_wdata | input | CNT_W (32) | Host write data |
| bus_rdata | output | CNT_W (32) | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle flag for a bad access |

## Verification
The bench builds the bank with CNT_W set to 12 and LEN_W left at 16. With 12-bit counters, a counter wraps after two 2048-byte frames, or after a single frame on a counter the host has preset just below 4095. Wrap-around of both the octet counters and the packet counters can therefore be reached in a few cycles. The 16-bit length still reaches every histogram threshold, including frames of 2048 bytes and above. The address map does not depend on CNT_W, so every valid, reserved, unused and out-of-window address is exercised at this width too.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int NUM_CNT  = 64;
  localparam int NUM_BIN  = 8;
  localparam int BIN_W    = $clog2(NUM_BIN);

  // transmit group
  localparam int TX_PKT      = 1;
  localparam int TX_FRAG     = 7;
  localparam int TX_BIN_BASE = 10;
  localparam int TX_OCT      = 17;
  localparam int TX_GOOD     = 19;
  localparam int TX_GOOD_OCT = 29;
  // receive group
  localparam int RX_PKT      = 33;
  localparam int RX_FRAG     = 39;
  localparam int RX_RSVD     = 41;
  localparam int RX_BIN_BASE = 42;
  localparam int RX_OCT      = 49;
  localparam int RX_GOOD     = 51;
  localparam int RX_GOOD_OCT = 56;

  localparam int TX_LAST_IDX = 29;
  localparam int RX_FIRST_IDX = 32;
  localparam int RX_LAST_IDX = 56;

  function automatic logic idx_used(int i);
    return (i >= 0 && i <= TX_LAST_IDX) || (i >= RX_FIRST_IDX && i <= RX_LAST_IDX);
  endfunction
endpackage

// File: rtl/mac_stat_size_bin.sv
module mac_stat_size_bin
  import mac_stat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  output logic [BIN_W-1:0] bin
);
  // bin 0: under 64, bin 1: exactly 64, bin k (2..6): under 32<<k, bin 7: rest
  always_comb begin
    if (len < LEN_W'(64)) begin
      bin = '0;
    end else if (len == LEN_W'(64)) begin
      bin = BIN_W'(1);
    end else begin
      bin = BIN_W'(NUM_BIN - 1);
      for (int k = NUM_BIN - 2; k >= 2; k--) begin
        if (len < LEN_W'(32 << k)) bin = BIN_W'(k);
      end
    end
  end
endmodule

// File: rtl/mac_stat_event_map.sv
module mac_stat_event_map
  import mac_stat_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int LEN_W        = 16,
  parameter int PKT_IDX      = 1,
  parameter int OCT_IDX      = 17,
  parameter int GOOD_IDX     = 19,
  parameter int GOOD_OCT_IDX = 29,
  parameter int FRAG_IDX     = 7,
  parameter int BIN_BASE     = 10
) (
  input  logic                            fire,
  input  logic [LEN_W-1:0]                len,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   delta
);
  logic [BIN_W-1:0] bin;
  logic [CNT_W-1:0] len_c;
  int               bin_idx;

  mac_stat_size_bin #(.LEN_W(LEN_W)) u_bin (.len(len), .bin(bin));

  assign len_c = CNT_W'(len);

  always_comb begin
    bin_idx = (bin == '0) ? FRAG_IDX : BIN_BASE + int'(bin) - 1;
    delta = '0;
    if (fire) begin
      delta[PKT_IDX]      = CNT_W'(1);
      delta[GOOD_IDX]     = CNT_W'(1);
      delta[OCT_IDX]      = len_c;
      delta[GOOD_OCT_IDX] = len_c;
      delta[bin_idx]      = CNT_W'(1);
    end
  end
endmodule

// File: rtl/mac_stat_host_dec.sv
module mac_stat_host_dec
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200,
  parameter int WIN_LAST = 'h2E0
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              bad,
  output logic [5:0]        idx
);
  logic in_win;
  logic good;
  int   off;

  always_comb begin
    in_win = (int'(addr) >= WIN_BASE) && (int'(addr) <= WIN_LAST) && (addr[1:0] == 2'b00);
    off    = (int'(addr) - WIN_BASE) >>> 2;
    idx    = in_win ? 6'(off) : 6'd0;
    good   = in_win && idx_used(int'(idx));
    rd_hit = sel && !wr && good;
    wr_hit = sel && wr && good;
    bad    = sel && !good;
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_err
);
  logic                          ready_q;
  logic                          tx_fire, rx_fire;
  logic [NUM_CNT-1:0][CNT_W-1:0] tx_delta, rx_delta;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic                          rd_hit, wr_hit, bad;
  logic [5:0]                    idx;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign tx_ready = ready_q;
  assign rx_ready = ready_q;
  assign tx_fire  = tx_valid && ready_q;
  assign rx_fire  = rx_valid && ready_q;

  mac_stat_event_map #(
    .CNT_W(CNT_W), .LEN_W(LEN_W),
    .PKT_IDX(TX_PKT), .OCT_IDX(TX_OCT), .GOOD_IDX(TX_GOOD),
    .GOOD_OCT_IDX(TX_GOOD_OCT), .FRAG_IDX(TX_FRAG), .BIN_BASE(TX_BIN_BASE)
  ) u_tx_map (.fire(tx_fire), .len(tx_len), .delta(tx_delta));

  mac_stat_event_map #(
    .CNT_W(CNT_W), .LEN_W(LEN_W),
    .PKT_IDX(RX_PKT), .OCT_IDX(RX_OCT), .GOOD_IDX(RX_GOOD),
    .GOOD_OCT_IDX(RX_GOOD_OCT), .FRAG_IDX(RX_FRAG), .BIN_BASE(RX_BIN_BASE)
  ) u_rx_map (.fire(rx_fire), .len(rx_len), .delta(rx_delta));

  mac_stat_host_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .bad(bad), .idx(idx)
  );

  // one register per used index; unused slots are tied to zero
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (idx_used(i)) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt[i] <= '0;
        else if (wr_hit && (int'(idx) == i))
          cnt[i] <= bus_wdata;
        else
          cnt[i] <= cnt[i] + tx_delta[i] + rx_delta[i];
      end
    end else begin : g_dead
      assign cnt[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? cnt[idx] : '0;
      bus_err   <= bad;
    end
  end
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk #(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  bus_rdata,
  input logic              bus_err
);
  logic acc_ok;
  always_comb begin
    acc_ok = (bus_addr >= ADDR_W'('h200)) && (bus_addr <= ADDR_W'('h2E0)) &&
             (bus_addr[1:0] == 2'b00) &&
             (bus_addr != ADDR_W'('h278)) && (bus_addr != ADDR_W'('h27C));
  end

  p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !acc_ok) |=> bus_err);
  p_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || acc_ok) |=> !bus_err);
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || bus_wr) |=> (bus_rdata == '0));
  p_wr_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && acc_ok) ##1 (bus_sel && !bus_wr && $stable(bus_addr))
      |=> (bus_rdata == $past(bus_wdata, 2)));
  p_ready_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_ready && rx_ready));
endmodule

bind mac_stat_bank mac_stat_bank_chk #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
);

// File: tb/mac_stat_bank_bench.sv
module mac_stat_bank_bench;
  localparam int CW = 12;
  localparam int LW = 16;
  localparam int AW = 12;
  localparam longint MASK = (64'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_valid = 0, rx_valid = 0, bus_sel = 0, bus_wr = 0;
  logic [LW-1:0] tx_len = '0, rx_len = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic          tx_ready, rx_ready, bus_err;
  logic [CW-1:0] bus_rdata;

  int     checks = 0;
  int     errors = 0;
  string  cur_req = "R1";
  bit     done = 0;

  longint m[64];
  longint exp_rdata = 0;
  bit     exp_err = 0;
  bit     exp_ready = 0;

  always #4 clk = ~clk;

  mac_stat_bank #(.CNT_W(CW), .LEN_W(LW), .ADDR_W(AW)) u_mac_stat_bank (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  function automatic int bucket(int len, bit rx);
    int b;
    if (len < 64) return rx ? 39 : 7;
    if (len == 64) b = 0;
    else if (len <= 127) b = 1;
    else if (len <= 255) b = 2;
    else if (len <= 511) b = 3;
    else if (len <= 1023) b = 4;
    else if (len <= 2047) b = 5;
    else b = 6;
    return (rx ? 42 : 10) + b;
  endfunction

  function automatic bit addr_ok(int a);
    int k;
    if (a < 'h200 || a > 'h2E0 || (a % 4) != 0) return 0;
    k = (a - 'h200) / 4;
    return !(k == 30 || k == 31);
  endfunction

  task automatic count_frame(int len, bit rx);
    int o = rx ? 32 : 0;
    m[1+o]  = (m[1+o] + 1) & MASK;
    m[19+o] = (m[19+o] + 1) & MASK;
    m[17+o] = (m[17+o] + len) & MASK;
    if (rx) m[56] = (m[56] + len) & MASK;
    else    m[29] = (m[29] + len) & MASK;
    m[bucket(len, rx)] = (m[bucket(len, rx)] + 1) & MASK;
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      exp_rdata = 0; exp_err = 0; exp_ready = 0;
    end else begin
      bit ok;
      int k;
      ok = addr_ok(int'(bus_addr));
      k  = ok ? (int'(bus_addr) - 'h200) / 4 : 0;
      exp_rdata = (bus_sel && !bus_wr && ok) ? m[k] : 0;
      exp_err   = bus_sel && !ok;
      if (tx_valid && exp_ready) count_frame(int'(tx_len), 0);
      if (rx_valid && exp_ready) count_frame(int'(rx_len), 1);
      if (bus_sel && bus_wr && ok) m[k] = longint'(bus_wdata);
      exp_ready = 1;
    end
  end

  // comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (longint'(bus_rdata) != exp_rdata || bus_err !== exp_err ||
          tx_ready !== exp_ready || rx_ready !== exp_ready) begin
        errors++;
        $display("FAIL %s: rdata=%0h err=%0b rdy=%0b%0b expected rdata=%0h err=%0b rdy=%0b",
                 cur_req, bus_rdata, bus_err, tx_ready, rx_ready, exp_rdata, exp_err, exp_ready);
      end
    end
  end

  task automatic cyc(bit tv, int tl, bit rv, int rl, bit s, bit w, int a, int d);
    @(negedge clk); #1;
    tx_valid = tv; tx_len = LW'(tl);
    rx_valid = rv; rx_len = LW'(rl);
    bus_sel = s; bus_wr = w; bus_addr = AW'(a); bus_wdata = CW'(d);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_all();
    for (int a = 'h200; a < 'h300; a += 4) cyc(0, 0, 0, 0, 1, 0, a, 0);
    idle();
  endtask

  int lens[15] = '{1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048, 3000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of all counters, ready rises
    cur_req = "R1"; idle(); read_all();
    // R2 R3 R4: transmit frames across every threshold
    cur_req = "R4";
    foreach (lens[i]) cyc(1, lens[i], 0, 0, 0, 0, 0, 0);
    idle(); cur_req = "R2"; read_all();
    // R5: receive frames, reserved index 41 stays untouched
    cur_req = "R5";
    foreach (lens[i]) cyc(0, 0, 1, lens[i], 0, 0, 0, 0);
    idle(); cur_req = "R3"; read_all();
    // R6: both directions in the same cycles
    cur_req = "R6";
    for (int i = 0; i < 6; i++) cyc(1, 60 + i * 300, 1, 2100 - i * 350, 0, 0, 0, 0);
    idle(); read_all();
    // R7: wrap of octet and packet counters
    cur_req = "R7";
    cyc(0, 0, 0, 0, 1, 1, 'h200 + 4 * 17, 'hFF0);
    cyc(0, 0, 0, 0, 1, 1, 'h200 + 4 * 1, 'hFFF);
    cyc(0, 0, 0, 0, 1, 1, 'h200 + 4 * 49, 'hFFE);
    cyc(1, 40, 1, 3, 0, 0, 0, 0);
    cyc(1, 2048, 0, 0, 0, 0, 0, 0);
    idle(); read_all();
    // R8: write then read back, read during an update returns old value
    cur_req = "R8";
    cyc(0, 0, 0, 0, 1, 1, 'h200 + 4 * 41, 'h5A5);
    cyc(0, 0, 0, 0, 1, 0, 'h200 + 4 * 41, 0);
    cyc(0, 0, 0, 0, 1, 1, 'h200 + 4 * 4, 'h123);
    cyc(0, 0, 0, 0, 1, 0, 'h200 + 4 * 4, 0);
    cyc(1, 100, 0, 0, 1, 0, 'h200 + 4 * 1, 0);
    cyc(0, 0, 1, 64, 1, 0, 'h200 + 4 * 42, 0);
    idle(); read_all();
    // R9: host write collides with a frame update
    cur_req = "R9";
    cyc(1, 70, 0, 0, 1, 1, 'h200 + 4 * 1, 'h777);
    cyc(0, 0, 1, 300, 1, 1, 'h200 + 4 * 45, 'h010);
    cyc(0, 0, 0, 0, 1, 0, 'h200 + 4 * 1, 0);
    idle(); read_all();
    // R10: bad accesses are ignored and flagged
    cur_req = "R10";
    cyc(0, 0, 0, 0, 1, 1, 'h100, 'hABC);
    cyc(0, 0, 0, 0, 1, 1, 'h278, 'hABC);
    cyc(0, 0, 0, 0, 1, 1, 'h27C, 'hABC);
    cyc(0, 0, 0, 0, 1, 1, 'h2E4, 'hABC);
    cyc(0, 0, 0, 0, 1, 1, 'h202, 'hABC);
    cyc(0, 0, 0, 0, 1, 1, 'hA00, 'hABC);
    cyc(0, 0, 0, 0, 1, 0, 'h2FC, 0);
    cyc(0, 0, 0, 0, 1, 0, 'h0FC, 0);
    idle(); read_all();
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule